// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block sits between a processor's load port and memory, and turns each virtual address into a physical one. The table it walks is flat, with one level, and lives in memory. An accepted load address is cut into a 20-bit virtual page number and a 12-bit in-page offset, for 4 KB pages. The walker adds the page number, scaled by four bytes, to a software-written base register to get the address of the table entry. It reads that entry over a shared memory request port. If the entry is marked present, the walker issues a second memory read at the translated address and hands the returned word back to the processor. If the entry is not present, no second read is made. Instead a one-cycle fault pulse is raised, carrying the offending virtual address, so that a handler can repair the entry and reissue the load.

Only one translation is in flight at a time. The controller has six named states:

- IDLE: accepts a request.
- FETCH_PTE: presents the entry read.
- WAIT_PTE: waits for the entry.
- ACCESS: presents the translated read.
- WAIT_DATA: waits for the data word.
- FAULT: pulses the exception.

Its transitions are:

- IDLE→FETCH_PTE on request handshake.
- FETCH_PTE→WAIT_PTE on memory ready.
- WAIT_PTE→ACCESS on a present entry.
- WAIT_PTE→FAULT on an absent entry.
- ACCESS→WAIT_DATA on memory ready.
- WAIT_DATA→IDLE on data return.
- FAULT→IDLE unconditionally.

Top module: `ptw_mmu`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `cpu_fault` and `mem_req_valid` are all 0.
- R2: The first memory request of every translation has address base + (vaddr[31:12] × 4).
- R3: A table entry is present when its bit 0 is 1. For a present entry, the second memory request has address {entry[31:12], vaddr[11:0]}. This holds for offsets 0x000 and 0xFFF alike.
- R4: The word returned for the second request appears on `cpu_rsp_data`, with `cpu_rsp_valid` high for exactly one cycle.
- R5: When entry bit 0 is 0, the walker makes no second memory request and never raises `cpu_rsp_valid` for that load. It raises `cpu_fault` for exactly one cycle, with `cpu_fault_vaddr` equal to the faulting virtual address.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged address.
- R7: `cpu_req_ready` is 1 only in IDLE, so at most one translation is outstanding.
- R8: A write on `base_wr_en` takes effect only when the walker is idle. A write made while a translation is in progress is dropped, and later entry addresses still use the old base.
- R9: Entries are never cached. A load retried after a fault reads the entry again and translates with the newly written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Load request valid |
| cpu_req_ready | output | 1 | Walker can accept a load |
| cpu_req_vaddr | input | 32 | Virtual address of the load |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_data | output | 32 | Load data word |
| cpu_fault | output | 1 | Page-fault pulse |
| cpu_fault_vaddr | output | 32 | Virtual address that faulted |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 32 | New table base address |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The hardest case to reach from the ports is a base-register write that arrives while a walk is in progress. Reaching it needs a write strobe that lands after the request handshake but before the data returns. The stimulus therefore starts a load and pulses the base write on the very next falling edge, while the walker sits in FETCH_PTE. A second load then shows, through its entry address, that the old base survived. The fault-then-retry sequence is just as indirect, because the bench memory model has to rewrite the entry between the two loads. Only the second load's physical address proves that the entry was read again rather than reused.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_PTE,
        ST_WAIT_PTE,
        ST_ACCESS,
        ST_WAIT_DATA,
        ST_FAULT
    } walk_state_t;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
    parameter int          AW         = 32,
    parameter logic [31:0] RESET_BASE = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          idle,
    output logic [AW-1:0] base_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base_q <= AW'(RESET_BASE);
        else if (wr_en && idle)
            base_q <= wr_data;
    end

    // Hold the base whenever the walker was busy (R8).
    assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(base_q));
endmodule

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_BITS   = 12,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [PA_W-1:0]           base,
    input  logic [VA_W-1:0]           vaddr,
    input  logic [PA_W-PAGE_BITS-1:0] ppn,
    output logic [PA_W-1:0]           pte_addr,
    output logic [PA_W-1:0]           phys_addr
);
    localparam int VPN_W = VA_W - PAGE_BITS;

    logic [VPN_W-1:0] vpn;

    assign vpn       = vaddr[VA_W-1:PAGE_BITS];
    assign pte_addr  = base + ({{(PA_W-VPN_W){1'b0}}, vpn} << ENTRY_SHIFT);
    assign phys_addr = {ppn, vaddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/ptw_mmu.sv
module ptw_mmu
    import ptw_pkg::*;
#(
    parameter int          VA_W        = 32,
    parameter int          PA_W        = 32,
    parameter int          PTE_W       = 32,
    parameter int          PAGE_BITS   = 12,
    parameter int          ENTRY_SHIFT = 2,
    parameter int          VALID_BIT   = 0,
    parameter logic [31:0] RESET_BASE  = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req_valid,
    output logic            cpu_req_ready,
    input  logic [VA_W-1:0] cpu_req_vaddr,
    output logic            cpu_rsp_valid,
    output logic [PTE_W-1:0] cpu_rsp_data,
    output logic            cpu_fault,
    output logic [VA_W-1:0] cpu_fault_vaddr,
    input  logic            base_wr_en,
    input  logic [PA_W-1:0] base_wr_data,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    localparam int PPN_W = PA_W - PAGE_BITS;

    walk_state_t state, next_state;

    logic [VA_W-1:0]  vaddr_q;
    logic [PPN_W-1:0] ppn_q;
    logic [PA_W-1:0]  base_q;
    logic [PA_W-1:0]  pte_addr;
    logic [PA_W-1:0]  phys_addr;
    logic             rsp_valid_q;
    logic [PTE_W-1:0] rsp_data_q;
    logic             idle;

    assign idle = (state == ST_IDLE);

    ptw_base_reg #(
        .AW(PA_W), .RESET_BASE(RESET_BASE)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .wr_en(base_wr_en), .wr_data(base_wr_data),
        .idle(idle), .base_q(base_q)
    );

    ptw_addr_calc #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_addr (
        .base(base_q), .vaddr(vaddr_q), .ppn(ppn_q),
        .pte_addr(pte_addr), .phys_addr(phys_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:      if (cpu_req_valid) next_state = ST_FETCH_PTE;
            ST_FETCH_PTE: if (mem_req_ready) next_state = ST_WAIT_PTE;
            ST_WAIT_PTE:  if (mem_rsp_valid)
                              next_state = mem_rsp_data[VALID_BIT] ? ST_ACCESS : ST_FAULT;
            ST_ACCESS:    if (mem_req_ready) next_state = ST_WAIT_DATA;
            ST_WAIT_DATA: if (mem_rsp_valid) next_state = ST_IDLE;
            ST_FAULT:     next_state = ST_IDLE;
            default:      next_state = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            ppn_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (idle && cpu_req_valid)
                vaddr_q <= cpu_req_vaddr;
            if (state == ST_WAIT_PTE && mem_rsp_valid)
                ppn_q <= mem_rsp_data[PTE_W-1 -: PPN_W];
            if (state == ST_WAIT_DATA && mem_rsp_valid) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= mem_rsp_data;
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_req_ready   = 1'b0;
        mem_req_valid   = 1'b0;
        mem_req_addr    = '0;
        cpu_fault       = 1'b0;
        cpu_fault_vaddr = '0;
        unique case (state)
            ST_IDLE:      cpu_req_ready = 1'b1;
            ST_FETCH_PTE: begin mem_req_valid = 1'b1; mem_req_addr = pte_addr;  end
            ST_WAIT_PTE:  ;
            ST_ACCESS:    begin mem_req_valid = 1'b1; mem_req_addr = phys_addr; end
            ST_WAIT_DATA: ;
            ST_FAULT:     begin cpu_fault = 1'b1; cpu_fault_vaddr = vaddr_q; end
            default:      ;
        endcase
    end

    assign cpu_rsp_valid = rsp_valid_q;
    assign cpu_rsp_data  = rsp_data_q;

    assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fault |=> !cpu_fault);
    assert_fault_no_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_fault && cpu_rsp_valid));
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS) |-> (mem_req_addr[PAGE_BITS-1:0] == vaddr_q[PAGE_BITS-1:0]));
    assert_rsp_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> ($past(state) == ST_WAIT_DATA));
    assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_ready |-> !mem_req_valid);
endmodule

// File: tb/ptw_mmu_test.sv
module ptw_mmu_test;
    localparam logic [31:0] BASE_A = 32'h0001_0000;
    localparam logic [31:0] BASE_B = 32'h0001_0400;

    // {use BASE_B, virtual address}
    localparam logic [32:0] VECS [8] = '{
        {1'b0, 32'h0000_0000}, {1'b0, 32'h0000_1FFF}, {1'b0, 32'h0000_2123},
        {1'b0, 32'h000F_F000}, {1'b1, 32'h0000_3ABC}, {1'b1, 32'h0000_1004},
        {1'b0, 32'h0000_5555}, {1'b1, 32'h0004_1800}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic [31:0] cpu_req_vaddr = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_data;
    logic        cpu_fault;
    logic [31:0] cpu_fault_vaddr;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    ptw_mmu uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_vaddr(cpu_req_vaddr), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_data(cpu_rsp_data), .cpu_fault(cpu_fault),
        .cpu_fault_vaddr(cpu_fault_vaddr), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] pte_mem [512];
    logic [31:0] req_log [64];
    int          nreq = 0;
    int          hold_err = 0;
    bit          ready_gap = 1'b0;
    logic [31:0] cur_base = '0;

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        if (a[31:16] == 16'h0001) return pte_mem[a[10:2]];
        return a ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: one-cycle latency, optional alternating ready.
    initial begin
        int cnt = 0;
        logic [31:0] pend = '0;
        bit prev_stall = 1'b0;
        logic [31:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (prev_stall && (!mem_req_valid || mem_req_addr !== prev_addr)) hold_err++;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pend; end
            end
            mem_req_ready = ready_gap ? ~mem_req_ready : 1'b1;
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            if (mem_req_valid && mem_req_ready && cnt == 0 && !mem_rsp_valid) begin
                pend = mem_model(mem_req_addr);
                req_log[nreq & 63] = mem_req_addr;
                nreq++;
                cnt = 1;
            end
        end
    end

    logic        got_rsp, got_fault, busy_ready;
    logic [31:0] got_data, got_fva;
    int          first_req;

    task automatic write_base(input logic [31:0] b);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
        cur_base = b;
    endtask

    task automatic do_load(input logic [31:0] va, input bit wr_busy, input logic [31:0] wv);
        got_rsp = 1'b0; got_fault = 1'b0; got_data = '0; got_fva = '0;
        @(negedge clk);
        first_req = nreq;
        cpu_req_valid = 1'b1; cpu_req_vaddr = va;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        busy_ready = cpu_req_ready;
        if (wr_busy) begin
            base_wr_en = 1'b1; base_wr_data = wv;
            @(negedge clk);
            base_wr_en = 1'b0;
        end
        for (int i = 0; i < 200; i++) begin
            if (cpu_rsp_valid) begin got_rsp = 1'b1; got_data = cpu_rsp_data; break; end
            if (cpu_fault)     begin got_fault = 1'b1; got_fva = cpu_fault_vaddr; break; end
            @(negedge clk);
        end
        @(negedge clk);
        chk("R4/R5 pulse ends", {30'b0, cpu_rsp_valid, cpu_fault}, 32'h0);
    endtask

    task automatic check_load(input logic [31:0] va, input logic [31:0] base);
        logic [31:0] pa_exp, pte;
        logic [31:0] pte_addr_exp;
        pte_addr_exp = base + {va[31:12], 2'b00};
        pte = pte_mem[pte_addr_exp[10:2]];
        chk("R7 busy ready low", {31'b0, busy_ready}, 32'h0);
        chk("R2 entry address", req_log[first_req & 63], pte_addr_exp);
        if (!pte[0]) begin
            chk("R5 fault raised", {31'b0, got_fault}, 32'h1);
            chk("R5 fault vaddr", got_fva, va);
            chk("R5 no data request", nreq - first_req, 32'd1);
            chk("R5 no response", {31'b0, got_rsp}, 32'h0);
        end else begin
            pa_exp = {pte[31:12], va[11:0]};
            chk("R3 physical address", req_log[(first_req + 1) & 63], pa_exp);
            chk("R4 response seen", {31'b0, got_rsp}, 32'h1);
            chk("R4 response data", got_data, pa_exp ^ 32'hA5A5_0000);
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++)
            pte_mem[i] = {20'h80000 + 20'(i), 11'h0, (i % 3 != 2)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, cpu_req_ready}, 32'h1);
        chk("R1 idle outputs", {29'b0, cpu_rsp_valid, cpu_fault, mem_req_valid}, 32'h0);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            logic [31:0] b;
            b = VECS[v][32] ? BASE_B : BASE_A;
            if (b !== cur_base) write_base(b);
            do_load(VECS[v][31:0], 1'b0, '0);
            check_load(VECS[v][31:0], b);
        end

        // R6: memory backpressure
        ready_gap = 1'b1;
        hold_err = 0;
        do_load(32'h0000_4ABC, 1'b0, '0);
        check_load(32'h0000_4ABC, cur_base);
        chk("R6 request held under stall", hold_err, 32'd0);
        ready_gap = 1'b0;

        // R8: base write during a walk is dropped
        write_base(BASE_A);
        do_load(32'h0000_3000, 1'b1, BASE_B);
        check_load(32'h0000_3000, BASE_A);
        do_load(32'h0000_4000, 1'b0, '0);
        chk("R8 old base kept", req_log[first_req & 63], BASE_A + 32'h10);

        // R9: fault, repair entry, retry
        do_load(32'h0000_2123, 1'b0, '0);
        chk("R9 initial fault", {31'b0, got_fault}, 32'h1);
        pte_mem[2] = {20'hC0DE0, 12'h001};
        do_load(32'h0000_2123, 1'b0, '0);
        chk("R9 retry physical address", req_log[(first_req + 1) & 63], 32'hC0DE_0123);
        chk("R9 retry data", got_data, 32'hC0DE_0123 ^ 32'hA5A5_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule